// File: doc/BRIEF.md
# Melody and Buzzer Tone Generator

This block drives a single-bit audio line for a small controller. It runs in one of two modes chosen by a control register. In melody mode, software hands over notes one at a time. Each note is a scale code that picks a pitch and a length code that picks a duration. A tempo register sets how many clocks one length step lasts. The note engine plays the current note while the next one waits in a one-deep holding buffer. It raises a one-clock interrupt pulse each time it takes a note from that buffer, so software knows it can load the following note.

In buzzer mode the block produces a rectangular tone. Software picks one of eight periods and one of sixteen duty levels, and one of four gating patterns: silent, continuous, a single burst of a fixed number of periods, or a repeating on/off rhythm. The clock is expected to run at twice the 32.768 kHz reference (65.536 kHz). A half period of one clock therefore gives a 32.768 kHz tone, and the longest melody half period of 64 clocks gives 512 Hz.

Writes arrive on a plain write-only register port. Clearing the enable bit silences the output at the write edge and discards all note and pattern state.

Top module: `chime_core`

## Requirements
- R1: After reset, audio_out and note_irq are low and every register is zero. The register map by wr_addr is: 0 control ([0] enable, [1] mode with 1 = buzzer, [3:2] pattern); 1 tempo ([3:0]); 2 buzzer ([3:0] duty, [6:4] period select); 3 scale staging ([4:0]); 4 length ([5:0]). A write to address 4 commits a note made of the staged scale and the written length.
- R2: A control write with enable 0 drives audio_out low from that write edge onward. It drops any playing or buffered note, so no later note_irq comes from notes written before it.
- R3: Scale codes 0 to 28 give a half period in clocks from this list in code order: 64,60,57,54,51,48,45,43,40,38,36,34,32,30,28,27,25,24,22,20,18,16,14,12,10,8,4,2,1. The output of a note is low on the load edge and toggles every half period after it.
- R4: Scale codes 29 to 31 are rests. The output stays low for the full note duration.
- R5: A note lasts length × T × TICK_UNIT clocks, where T is the tempo value, and a tempo value of 0 counts as 1.
- R6: A length write of 0 commits nothing. No note_irq follows and the output stays low.
- R7: A committed note waits in a one-deep buffer and is loaded when no note is playing or on the closing edge of the current note. Each load gives a one-clock note_irq pulse, and each note starts with audio_out low.
- R8: In buzzer mode with period select f and duty d, the tone period is 16·2^f clocks and the output is high for the first d·2^f clocks of each period. Counting starts on the second edge after the control write.
- R9: Pattern 1 is continuous. Pattern 3 gives GATE_PERIODS tone periods on, then GATE_PERIODS periods silent, repeating.
- R10: Pattern 2 plays BURST_PERIODS tone periods after the control write, then stays low.
- R11: Pattern 0, or duty 0, keeps audio_out low in buzzer mode.
- R12: A note commit is ignored while the block is disabled or in buzzer mode, and note_irq is only ever high while enabled in melody mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock, nominally 65.536 kHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| audio_out | output | 1 | Single-bit tone output |
| note_irq | output | 1 | One-clock pulse when a buffered note is taken |

## Verification
The bench builds the block with TICK_UNIT = 2, BURST_PERIODS = 3 and GATE_PERIODS = 2. With these values a whole note, a complete single-shot burst and several on/off gate cycles each fit in a few hundred clocks. The bench can therefore compare every output cycle against its own waveform model, including the closing edge of each note, a queued note handed over mid-play, and bursts at several period selects.

// File: rtl/chime_pkg.sv
package chime_pkg;

    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned SCALE_W   = 5;
    localparam int unsigned LEN_W     = 6;
    localparam int unsigned TEMPO_W   = 4;
    localparam int unsigned DUTY_W    = 4;
    localparam int unsigned BFREQ_W   = 3;
    localparam int unsigned HALF_W    = 7;
    localparam int unsigned NUM_TONES = 29;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TEMPO = 3'd1;
    localparam logic [ADDR_W-1:0] A_BUZZ  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SCALE = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEN   = 3'd4;

    typedef enum logic [1:0] {
        PAT_OFF    = 2'd0,
        PAT_CONT   = 2'd1,
        PAT_SINGLE = 2'd2,
        PAT_GATED  = 2'd3
    } buzz_pat_e;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [LEN_W-1:0]   len;
    } note_t;

    // Half period in clocks for each pitch code; codes past the table are rests.
    function automatic logic [HALF_W-1:0] tone_half(input logic [SCALE_W-1:0] code);
        case (code)
            5'd0:  tone_half = 7'd64;
            5'd1:  tone_half = 7'd60;
            5'd2:  tone_half = 7'd57;
            5'd3:  tone_half = 7'd54;
            5'd4:  tone_half = 7'd51;
            5'd5:  tone_half = 7'd48;
            5'd6:  tone_half = 7'd45;
            5'd7:  tone_half = 7'd43;
            5'd8:  tone_half = 7'd40;
            5'd9:  tone_half = 7'd38;
            5'd10: tone_half = 7'd36;
            5'd11: tone_half = 7'd34;
            5'd12: tone_half = 7'd32;
            5'd13: tone_half = 7'd30;
            5'd14: tone_half = 7'd28;
            5'd15: tone_half = 7'd27;
            5'd16: tone_half = 7'd25;
            5'd17: tone_half = 7'd24;
            5'd18: tone_half = 7'd22;
            5'd19: tone_half = 7'd20;
            5'd20: tone_half = 7'd18;
            5'd21: tone_half = 7'd16;
            5'd22: tone_half = 7'd14;
            5'd23: tone_half = 7'd12;
            5'd24: tone_half = 7'd10;
            5'd25: tone_half = 7'd8;
            5'd26: tone_half = 7'd4;
            5'd27: tone_half = 7'd2;
            default: tone_half = 7'd1;
        endcase
    endfunction

endpackage

// File: rtl/chime_regs.sv
module chime_regs
    import chime_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                en,
    output logic                mode,
    output buzz_pat_e           pattern,
    output logic [TEMPO_W-1:0]  tempo,
    output logic [DUTY_W-1:0]   duty,
    output logic [BFREQ_W-1:0]  bfreq,
    output logic                ctrl_wr,
    output logic                mel_clear,
    output logic                commit,
    output note_t               commit_note
);

    typedef struct packed {
        logic               en;
        logic               mode;
        buzz_pat_e          pattern;
        logic [TEMPO_W-1:0] tempo;
        logic [DUTY_W-1:0]  duty;
        logic [BFREQ_W-1:0] bfreq;
        logic [SCALE_W-1:0] stage;
    } reg_state_t;

    reg_state_t q, d;

    always_comb begin
        d           = q;
        ctrl_wr     = wr_en && (wr_addr == A_CTRL);
        mel_clear   = ctrl_wr && (!wr_data[0] || wr_data[1]);
        commit      = wr_en && (wr_addr == A_LEN) && q.en && !q.mode
                      && (wr_data[LEN_W-1:0] != '0);
        commit_note = '{scale: q.stage, len: wr_data[LEN_W-1:0]};
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    d.en      = wr_data[0];
                    d.mode    = wr_data[1];
                    d.pattern = buzz_pat_e'(wr_data[3:2]);
                end
                A_TEMPO: d.tempo = wr_data[TEMPO_W-1:0];
                A_BUZZ: begin
                    d.duty  = wr_data[DUTY_W-1:0];
                    d.bfreq = wr_data[DUTY_W+BFREQ_W-1:DUTY_W];
                end
                A_SCALE: d.stage = wr_data[SCALE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en      = q.en;
    assign mode    = q.mode;
    assign pattern = q.pattern;
    assign tempo   = q.tempo;
    assign duty    = q.duty;
    assign bfreq   = q.bfreq;

endmodule

// File: rtl/chime_melody.sv
module chime_melody
    import chime_pkg::*;
#(
    parameter int unsigned TICK_UNIT = 64
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clear,
    input  logic               commit,
    input  note_t              commit_note,
    input  logic [TEMPO_W-1:0] tempo,
    output logic               tone,
    output logic               irq
);

    localparam int unsigned TICK_MAX = ((1 << TEMPO_W) - 1) * TICK_UNIT;
    localparam int unsigned TICK_W   = $clog2(TICK_MAX + 1);

    typedef struct packed {
        logic               buf_v;
        note_t              buf_n;
        logic               cur_v;
        note_t              cur_n;
        logic [LEN_W-1:0]   len_cnt;
        logic [TICK_W-1:0]  tick_cnt;
        logic [HALF_W-1:0]  tone_cnt;
        logic               out;
        logic               irq;
    } mel_state_t;

    mel_state_t q, d;

    logic [TEMPO_W-1:0] tempo_eff;
    logic [TICK_W-1:0]  tick_last;
    logic [HALF_W-1:0]  half;
    logic               audible;
    logic               note_end;

    always_comb begin
        tempo_eff = (tempo == '0) ? TEMPO_W'(1) : tempo;
        tick_last = TICK_W'(32'(tempo_eff) * TICK_UNIT - 32'd1);
        half      = tone_half(q.cur_n.scale);
        audible   = q.cur_n.scale < SCALE_W'(NUM_TONES);
        note_end  = q.cur_v && (q.tick_cnt == tick_last)
                    && (q.len_cnt == q.cur_n.len - LEN_W'(1));

        d     = q;
        d.irq = 1'b0;

        if (q.cur_v) begin
            if (q.tone_cnt >= half - HALF_W'(1)) begin
                d.tone_cnt = '0;
                d.out      = audible && !q.out;
            end else begin
                d.tone_cnt = q.tone_cnt + HALF_W'(1);
            end
            if (q.tick_cnt >= tick_last) begin
                d.tick_cnt = '0;
                d.len_cnt  = q.len_cnt + LEN_W'(1);
            end else begin
                d.tick_cnt = q.tick_cnt + TICK_W'(1);
            end
        end

        if (q.buf_v && (!q.cur_v || note_end)) begin
            d.cur_v    = 1'b1;
            d.cur_n    = q.buf_n;
            d.buf_v    = 1'b0;
            d.len_cnt  = '0;
            d.tick_cnt = '0;
            d.tone_cnt = '0;
            d.out      = 1'b0;
            d.irq      = 1'b1;
        end else if (note_end) begin
            d.cur_v    = 1'b0;
            d.len_cnt  = '0;
            d.tick_cnt = '0;
            d.tone_cnt = '0;
            d.out      = 1'b0;
        end

        if (commit) begin
            d.buf_v = 1'b1;
            d.buf_n = commit_note;
        end

        if (!run || clear) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tone = q.out;
    assign irq  = q.irq;

endmodule

// File: rtl/chime_buzzer.sv
module chime_buzzer
    import chime_pkg::*;
#(
    parameter int unsigned BURST_PERIODS = 8,
    parameter int unsigned GATE_PERIODS  = 4
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  buzz_pat_e          pattern,
    input  logic [DUTY_W-1:0]  duty,
    input  logic [BFREQ_W-1:0] bfreq,
    output logic               tone
);

    localparam int unsigned PC_W    = DUTY_W + (1 << BFREQ_W) - 1;
    localparam int unsigned PER_MAX = (BURST_PERIODS > 2 * GATE_PERIODS)
                                      ? BURST_PERIODS : 2 * GATE_PERIODS;
    localparam int unsigned PER_W   = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [PC_W-1:0]  pcnt;
        logic [PER_W-1:0] per;
        logic             out;
    } buz_state_t;

    buz_state_t q, d;

    logic [PC_W-1:0] per_last;
    logic [PC_W-1:0] high_len;
    logic            gate_on;

    always_comb begin
        per_last = PC_W'((32'd16 << bfreq) - 32'd1);
        high_len = PC_W'(32'(duty) << bfreq);
        case (pattern)
            PAT_CONT:   gate_on = 1'b1;
            PAT_SINGLE: gate_on = q.per < PER_W'(BURST_PERIODS);
            PAT_GATED:  gate_on = q.per < PER_W'(GATE_PERIODS);
            default:    gate_on = 1'b0;
        endcase

        d     = q;
        d.out = run && gate_on && (q.pcnt < high_len);

        if (run) begin
            if (q.pcnt >= per_last) begin
                d.pcnt = '0;
                case (pattern)
                    PAT_SINGLE: if (q.per < PER_W'(BURST_PERIODS))
                                    d.per = q.per + PER_W'(1);
                    PAT_GATED:  d.per = (q.per >= PER_W'(2 * GATE_PERIODS - 1))
                                        ? '0 : q.per + PER_W'(1);
                    default:    d.per = '0;
                endcase
            end else begin
                d.pcnt = q.pcnt + PC_W'(1);
            end
        end else begin
            d = '0;
        end

        if (restart) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tone = q.out;

endmodule

// File: rtl/chime_core.sv
module chime_core
    import chime_pkg::*;
#(
    parameter int unsigned TICK_UNIT     = 64,
    parameter int unsigned BURST_PERIODS = 8,
    parameter int unsigned GATE_PERIODS  = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              audio_out,
    output logic              note_irq
);

    logic               reg_en;
    logic               reg_mode;
    buzz_pat_e          reg_pat;
    logic [TEMPO_W-1:0] reg_tempo;
    logic [DUTY_W-1:0]  reg_duty;
    logic [BFREQ_W-1:0] reg_bfreq;
    logic               ctrl_wr;
    logic               mel_clear;
    logic               commit;
    note_t              commit_note;
    logic               mel_tone;
    logic               buz_tone;

    chime_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .en          (reg_en),
        .mode        (reg_mode),
        .pattern     (reg_pat),
        .tempo       (reg_tempo),
        .duty        (reg_duty),
        .bfreq       (reg_bfreq),
        .ctrl_wr     (ctrl_wr),
        .mel_clear   (mel_clear),
        .commit      (commit),
        .commit_note (commit_note)
    );

    chime_melody #(.TICK_UNIT(TICK_UNIT)) u_melody (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (reg_en && !reg_mode),
        .clear       (mel_clear),
        .commit      (commit),
        .commit_note (commit_note),
        .tempo       (reg_tempo),
        .tone        (mel_tone),
        .irq         (note_irq)
    );

    chime_buzzer #(
        .BURST_PERIODS (BURST_PERIODS),
        .GATE_PERIODS  (GATE_PERIODS)
    ) u_buzzer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (reg_en && reg_mode),
        .restart (ctrl_wr),
        .pattern (reg_pat),
        .duty    (reg_duty),
        .bfreq   (reg_bfreq),
        .tone    (buz_tone)
    );

    assign audio_out = reg_mode ? buz_tone : mel_tone;

endmodule

// File: rtl/chime_core_checker.sv
module chime_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       mode,
    input logic [3:0] duty,
    input logic       audio_out,
    input logic       note_irq
);

    assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !audio_out);

    assert_irq_melody_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        note_irq |-> (en && !mode));

    assert_note_starts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        note_irq |-> !audio_out);

    assert_zero_duty_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && duty == 4'd0) |=> !audio_out);

endmodule

bind chime_core chime_core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (reg_en),
    .mode      (reg_mode),
    .duty      (reg_duty),
    .audio_out (audio_out),
    .note_irq  (note_irq)
);

// File: tb/chime_core_test.sv
`timescale 1ns/1ps
module chime_core_test;

    localparam int TICK  = 2;
    localparam int BURST = 3;
    localparam int GATE  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       audio_out;
    logic       note_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chime_core #(.TICK_UNIT(TICK), .BURST_PERIODS(BURST), .GATE_PERIODS(GATE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .audio_out(audio_out), .note_irq(note_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int half_of(input int s);
        int tbl[29] = '{64,60,57,54,51,48,45,43,40,38,36,34,32,30,28,27,25,24,22,
                        20,18,16,14,12,10,8,4,2,1};
        return tbl[s];
    endfunction

    function automatic bit mel_exp(input int s, input int k);
        if (s >= 29) return 1'b0;
        return ((k / half_of(s)) % 2) == 1;
    endfunction

    function automatic bit buz_exp(input int k, input int f, input int dty, input int p);
        int pb  = 16 << f;
        int per = k / pb;
        bit g;
        case (p)
            1: g = 1'b1;
            2: g = per < BURST;
            3: g = ((per / GATE) % 2) == 0;
            default: g = 1'b0;
        endcase
        return g && ((k % pb) < (dty << f));
    endfunction

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic reg_write(input int a, input int v);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watch n cycles for absence of irq and of output.
    task automatic quiet(input int n, input string req, input string what);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (note_irq || audio_out) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    // Entered at the falling edge right after the load edge (k = 0).
    task automatic run_note(input int s, input int len, input int tmp, input bit queue,
                            input int qs, input int qlen, input string req);
        int teff = (tmp == 0) ? 1 : tmp;
        int n = len * teff * TICK;
        int bad = 0;
        check(note_irq == 1'b1, "R7", "irq at note load", int'(note_irq), 1);
        for (int k = 0; k < n; k++) begin
            if (audio_out != mel_exp(s, k)) bad++;
            if (k > 0 && note_irq) bad++;
            if (queue && k == 1) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'(qs); end
            if (queue && k == 2) begin wr_addr = 3'd4; wr_data = 8'(qlen); end
            if (queue && k == 3) wr_en = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, req, "note waveform/duration mismatches", bad, 0);
        check(audio_out == 1'b0, "R5", "output low at note end", int'(audio_out), 0);
        check(note_irq == queue, "R7", "irq at note boundary", int'(note_irq), int'(queue));
    endtask

    task automatic play(input int s, input int len, input int tmp, input string req);
        reg_write(1, tmp);
        reg_write(3, s);
        reg_write(4, len);
        @(negedge clk);
        run_note(s, len, tmp, 1'b0, 0, 0, req);
    endtask

    task automatic buz_run(input int f, input int dty, input int p, input int ncyc,
                           input string req);
        int bad = 0;
        reg_write(2, (f << 4) | dty);
        reg_write(0, (p << 2) | 3);
        check(audio_out == 1'b0, req, "low on restart edge", int'(audio_out), 0);
        @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            if (audio_out != buz_exp(k, f, dty, p)) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, "buzzer waveform mismatches", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(audio_out == 1'b0, "R1", "reset audio_out", int'(audio_out), 0);
        check(note_irq == 1'b0, "R1", "reset note_irq", int'(note_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(5, "R1", "idle after reset");

        reg_write(0, 1);                       // melody, enabled
        play(0, 40, 3, "R3");                  // lowest pitch
        play(28, 3, 1, "R3");                  // highest pitch
        play(13, 5, 2, "R3");
        play(30, 4, 2, "R4");                  // rest
        play(31, 2, 1, "R4");
        play(20, 3, 0, "R5");                  // tempo 0 counts as 1

        reg_write(3, 5);                       // R6: zero length ignored
        reg_write(4, 0);
        quiet(12, "R6", "zero-length commit");

        // R7: queued note taken on the closing edge
        reg_write(1, 2);
        reg_write(3, 9);
        reg_write(4, 4);
        @(negedge clk);
        run_note(9, 4, 2, 1'b1, 26, 3, "R7");
        run_note(26, 3, 2, 1'b0, 0, 0, "R7");

        for (int i = 0; i < 6; i++) begin
            int s  = int'($urandom % 32);
            int ln = 2 + int'($urandom % 5);
            int t  = 1 + int'($urandom % 3);
            int qs = int'($urandom % 32);
            int ql = 2 + int'($urandom % 5);
            reg_write(1, t);
            reg_write(3, s);
            reg_write(4, ln);
            @(negedge clk);
            run_note(s, ln, t, 1'b1, qs, ql, "R3");
            run_note(qs, ql, t, 1'b0, 0, 0, "R5");
        end

        // R2: disable mid-note with a note waiting
        reg_write(1, 3);
        reg_write(3, 0);
        reg_write(4, 20);
        repeat (70) @(negedge clk);
        check(audio_out == 1'b1, "R2", "tone high before disable", int'(audio_out), 1);
        reg_write(4, 6);
        reg_write(0, 0);
        check(audio_out == 1'b0, "R2", "low right after disable", int'(audio_out), 0);
        reg_write(0, 1);
        quiet(30, "R2", "discarded notes after re-enable");

        // R12: commits ignored while disabled or in buzzer mode
        reg_write(0, 0);
        reg_write(3, 4);
        reg_write(4, 5);
        reg_write(0, 1);
        quiet(12, "R12", "commit while disabled");
        reg_write(0, 3);                       // buzzer, pattern off
        reg_write(3, 4);
        reg_write(4, 5);
        quiet(12, "R11", "pattern off");
        reg_write(0, 1);
        quiet(12, "R12", "commit in buzzer mode");

        buz_run(0, 8, 1, 64, "R8");
        buz_run(2, 3, 1, 200, "R8");
        buz_run(1, 15, 3, 32 * 9, "R9");
        buz_run(0, 4, 2, 16 * (BURST + 4), "R10");
        buz_run(1, 0, 1, 100, "R11");
        buz_run(0, 8, 0, 64, "R11");

        for (int i = 0; i < 6; i++) begin
            int f = int'($urandom % 3);
            int d = int'($urandom % 16);
            int p = int'($urandom % 4);
            buz_run(f, d, p, (16 << f) * (4 * GATE + 2), "R9");
        end

        // R2: disable while the buzzer output is high
        reg_write(2, 15);
        reg_write(0, 7);
        repeat (3) @(negedge clk);
        check(audio_out == 1'b1, "R8", "buzzer high at duty 15", int'(audio_out), 1);
        reg_write(0, 0);
        check(audio_out == 1'b0, "R2", "buzzer low after disable", int'(audio_out), 0);
        quiet(10, "R2", "stays low while disabled");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule